// File: doc/BRIEF.md
# Macro Call Parameter Front-End

This block sits on the method-write stream that a command decoder produces. Most method writes pass straight through to the downstream engine path. A window of method addresses is set aside for calling uploaded macros. Inside that window the addresses come in pairs. The even address of pair n is the call method: it starts macro n, and its data word becomes the macro's first parameter. The odd address of pair n is the parameter method: it appends one more parameter to a small parameter FIFO.

The first parameter is not placed in the FIFO. It is latched into a register and presented to the execution unit as the starting value of its first general-purpose register. A simple handshake stands in for the execution unit. A one-cycle start pulse comes with the macro index and the first parameter. A busy flag stays high until the unit pulses done. The unit reads further parameters through a pop port. It stalls for as long as the FIFO is empty, so a macro can consume as many parameters as the caller supplies.

Two conditions apply backpressure on the method input: a new call while a macro is still running, and a parameter write into a full FIFO. When a macro completes, any parameters it did not read are discarded.

Top module: `macro_call_fe`

## Requirements
- R1: A write whose method address lies outside [WIN_BASE, WIN_BASE + 2*NUM_MACROS) appears on the forward port in the same cycle with address and data unchanged, and m_ready then equals fwd_ready. A write inside the window never raises fwd_valid.
- R2: An accepted write to WIN_BASE + 2n (even offset) raises mac_start for exactly one cycle, starting the next cycle. From that cycle mac_busy is 1, mac_index is n and mac_r1 is the written data. mac_index and mac_r1 hold steady while the macro runs.
- R3: The data of a call write never enters the parameter FIFO: a call on its own leaves pop_valid unchanged.
- R4: An accepted write to WIN_BASE + 2n + 1 (odd offset) appends its data to the FIFO. Parameters leave the FIFO in the order they were written, one per cycle in which pop_req and pop_valid are both 1.
- R5: pop_valid is 1 exactly when the FIFO holds at least one parameter. pop_req while pop_valid is 0 removes nothing, and the engine waits.
- R6: A call write while mac_busy is 1 sees m_ready = 0 and has no effect. The same write is accepted in the first cycle after mac_busy falls.
- R7: A parameter write while the FIFO holds FIFO_DEPTH entries sees m_ready = 0 and leaves the FIFO contents unchanged. The FIFO never holds more than FIFO_DEPTH entries.
- R8: mac_done while mac_busy is 1 clears mac_busy and empties the FIFO. A parameter write accepted in that same cycle survives as the only entry.
- R9: mac_done while mac_busy is 0 has no effect. Parameters written before a call stay queued.
- R10: While rst_n is low, mac_start, mac_busy and pop_valid are 0, and mac_index and mac_r1 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_valid | input | 1 | Method write valid |
| m_ready | output | 1 | Method write accepted this cycle |
| m_addr | input | MTHD_W | Method address (word units) |
| m_data | input | 32 | Method data |
| fwd_valid | output | 1 | Forwarded write valid |
| fwd_ready | input | 1 | Downstream ready for forwarded writes |
| fwd_addr | output | MTHD_W | Forwarded method address |
| fwd_data | output | 32 | Forwarded method data |
| mac_start | output | 1 | One-cycle macro start pulse |
| mac_index | output | IDX_W | Index of the running macro |
| mac_r1 | output | 32 | First parameter, initial register value |
| mac_busy | output | 1 | Macro running |
| mac_done | input | 1 | Execution unit finished the macro |
| pop_req | input | 1 | Execution unit reads a parameter |
| pop_valid | output | 1 | A parameter is available |
| pop_data | output | 32 | Oldest queued parameter |

## Verification
The bench makes several functions coincide in a single cycle. Completion and a parameter write can land in the same cycle, and the write must survive the flush. A blocked call can be pending when completion arrives, and it must be accepted only in the following cycle. A pop and a refused push can meet at a full FIFO. A pop on an empty FIFO can coincide with the push that fills it, and nothing may be removed. Each case is created by driving the inputs together on one edge. A behavioural queue model predicts every output in every cycle, and the design's outputs are compared against that prediction.

// File: rtl/mcall_pkg.sv
package mcall_pkg;
  localparam int WORD_W = 32;

  // Classification of one method write against the macro window
  typedef enum logic [1:0] {
    MK_PASS  = 2'd0,
    MK_CALL  = 2'd1,
    MK_PARAM = 2'd2
  } mkind_e;
endpackage

// File: rtl/mcall_decode.sv
module mcall_decode
  import mcall_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 12'hE00,
  parameter int                NUM_MACROS = 128,
  localparam int               IDX_W      = $clog2(NUM_MACROS)
) (
  input  logic [ADDR_W-1:0] addr,
  output mkind_e            kind,
  output logic [IDX_W-1:0]  idx
);
  localparam int SPAN_I = 2 * NUM_MACROS;
  localparam logic [ADDR_W:0] SPAN = SPAN_I[ADDR_W:0];

  logic [ADDR_W:0] off;
  logic            in_win;

  always_comb begin
    off    = {1'b0, addr} - {1'b0, WIN_BASE};
    in_win = (addr >= WIN_BASE) && (off < SPAN);
    idx    = off[IDX_W:1];
    if (!in_win)     kind = MK_PASS;
    else if (off[0]) kind = MK_PARAM;
    else             kind = MK_CALL;
  end
endmodule

// File: rtl/mcall_ctrl.sv
module mcall_ctrl #(
  parameter int IDX_W  = 7,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_req,
  input  logic [IDX_W-1:0]  call_idx,
  input  logic [WORD_W-1:0] call_arg,
  input  logic              done_in,
  output logic              busy,
  output logic              start,
  output logic [IDX_W-1:0]  idx_q,
  output logic [WORD_W-1:0] r1_q,
  output logic              call_fire,
  output logic              flush
);
  logic              busy_q, busy_d, start_q, start_d;
  logic [IDX_W-1:0]  idx_d;
  logic [WORD_W-1:0] r1_d;

  always_comb begin
    call_fire = call_req && !busy_q;
    flush     = done_in && busy_q;
    start_d   = call_fire;
    busy_d    = busy_q;
    idx_d     = idx_q;
    r1_d      = r1_q;
    if (call_fire) begin
      busy_d = 1'b1;
      idx_d  = call_idx;
      r1_d   = call_arg;
    end else if (flush) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      idx_q   <= '0;
      r1_q    <= '0;
    end else begin
      busy_q  <= busy_d;
      start_q <= start_d;
      if (call_fire) begin
        idx_q <= idx_d;
        r1_q  <= r1_d;
      end
    end
  end

  assign busy  = busy_q;
  assign start = start_q;
endmodule

// File: rtl/mcall_fifo.sv
module mcall_fifo #(
  parameter int  DEPTH  = 4,
  parameter int  WORD_W = 32,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic              flush,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              full,
  output logic [CNT_W-1:0]  count
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              rd_ok;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_ok = rd_req && (cnt_q != '0) && !flush;
    wr_d  = wr_en ? step_ptr(wr_q) : wr_q;
    if (flush) begin
      rd_d  = wr_q;
      cnt_d = wr_en ? CNT_W'(1) : '0;
    end else begin
      rd_d  = rd_ok ? step_ptr(rd_q) : rd_q;
      cnt_d = cnt_q + CNT_W'(wr_en) - CNT_W'(rd_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage carries no reset; entries are only read once counted valid
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_q] <= wr_data;
  end

  assign rd_valid = (cnt_q != '0);
  assign rd_data  = mem[rd_q];
  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign count    = cnt_q;
endmodule

// File: rtl/macro_call_fe.sv
module macro_call_fe
  import mcall_pkg::*;
#(
  parameter int                MTHD_W     = 12,
  parameter logic [MTHD_W-1:0] WIN_BASE   = 12'hE00,
  parameter int                NUM_MACROS = 128,
  parameter int                FIFO_DEPTH = 4,
  localparam int               IDX_W      = $clog2(NUM_MACROS),
  localparam int               CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_valid,
  output logic              m_ready,
  input  logic [MTHD_W-1:0] m_addr,
  input  logic [WORD_W-1:0] m_data,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [MTHD_W-1:0] fwd_addr,
  output logic [WORD_W-1:0] fwd_data,
  output logic              mac_start,
  output logic [IDX_W-1:0]  mac_index,
  output logic [WORD_W-1:0] mac_r1,
  output logic              mac_busy,
  input  logic              mac_done,
  input  logic              pop_req,
  output logic              pop_valid,
  output logic [WORD_W-1:0] pop_data
);
  mkind_e           kind;
  logic [IDX_W-1:0] dec_idx;
  logic             call_try, param_try, call_fire, push_fire, flush, fifo_full;
  logic [CNT_W-1:0] fifo_cnt;

  mcall_decode #(
    .ADDR_W(MTHD_W), .WIN_BASE(WIN_BASE), .NUM_MACROS(NUM_MACROS)
  ) u_dec (
    .addr(m_addr), .kind(kind), .idx(dec_idx)
  );

  always_comb begin
    call_try  = m_valid && (kind == MK_CALL);
    param_try = m_valid && (kind == MK_PARAM);
    push_fire = param_try && !fifo_full;
    fwd_valid = m_valid && (kind == MK_PASS);
    unique case (kind)
      MK_CALL:  m_ready = !mac_busy;
      MK_PARAM: m_ready = !fifo_full;
      default:  m_ready = fwd_ready;
    endcase
  end

  assign fwd_addr = m_addr;
  assign fwd_data = m_data;

  mcall_ctrl #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .call_req(call_try), .call_idx(dec_idx), .call_arg(m_data),
    .done_in(mac_done),
    .busy(mac_busy), .start(mac_start), .idx_q(mac_index), .r1_q(mac_r1),
    .call_fire(call_fire), .flush(flush)
  );

  mcall_fifo #(.DEPTH(FIFO_DEPTH), .WORD_W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push_fire), .wr_data(m_data),
    .rd_req(pop_req), .flush(flush),
    .rd_valid(pop_valid), .rd_data(pop_data),
    .full(fifo_full), .count(fifo_cnt)
  );
endmodule

// File: rtl/mcall_chk.sv
module mcall_chk #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 7,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             m_ready,
  input logic             call_try,
  input logic             param_try,
  input logic             call_fire,
  input logic             push_fire,
  input logic             mac_start,
  input logic             mac_busy,
  input logic             mac_done,
  input logic [IDX_W-1:0] mac_index,
  input logic [31:0]      mac_r1,
  input logic             pop_valid,
  input logic             fifo_full,
  input logic [CNT_W-1:0] fifo_cnt
);
  assert_start_after_call_R2: assert property (@(posedge clk) disable iff (!rst_n)
    call_fire |=> (mac_start && mac_busy));

  assert_ctx_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_busy && !mac_done) |=> ($stable(mac_index) && $stable(mac_r1)));

  assert_call_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (call_try && mac_busy) |-> !m_ready);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (param_try && fifo_full) |-> !m_ready);

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(DEPTH));

  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_done && mac_busy) |=> (pop_valid == $past(push_fire)));
endmodule

bind macro_call_fe mcall_chk #(
  .DEPTH(FIFO_DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .m_ready(m_ready),
  .call_try(call_try), .param_try(param_try),
  .call_fire(call_fire), .push_fire(push_fire),
  .mac_start(mac_start), .mac_busy(mac_busy), .mac_done(mac_done),
  .mac_index(mac_index), .mac_r1(mac_r1),
  .pop_valid(pop_valid), .fifo_full(fifo_full), .fifo_cnt(fifo_cnt)
);

// File: tb/tb_macro_call_fe.sv
`timescale 1ns/1ps
module tb_macro_call_fe;
  localparam int DEPTH = 4;
  localparam int NUMM  = 128;
  localparam int BASE  = 'hE00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_valid = 1'b0;
  logic [11:0] m_addr = '0;
  logic [31:0] m_data = '0;
  logic        fwd_ready = 1'b0;
  logic        mac_done = 1'b0;
  logic        pop_req = 1'b0;
  logic        m_ready, fwd_valid, mac_start, mac_busy, pop_valid;
  logic [11:0] fwd_addr;
  logic [31:0] fwd_data, mac_r1, pop_data;
  logic [6:0]  mac_index;

  macro_call_fe #(.FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
    .m_addr(m_addr), .m_data(m_data), .fwd_valid(fwd_valid),
    .fwd_ready(fwd_ready), .fwd_addr(fwd_addr), .fwd_data(fwd_data),
    .mac_start(mac_start), .mac_index(mac_index), .mac_r1(mac_r1),
    .mac_busy(mac_busy), .mac_done(mac_done), .pop_req(pop_req),
    .pop_valid(pop_valid), .pop_data(pop_data)
  );

  always #2.5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit fin = 1'b0;

  // Behavioural reference model
  bit          e_busy = 0, e_start = 0;
  int          e_idx = 0;
  logic [31:0] e_r1 = '0;
  logic [31:0] q[$];

  function automatic bit in_win(input logic [11:0] a);
    return (int'(a) >= BASE) && (int'(a) < BASE + 2 * NUMM);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_busy = 0; e_start = 0; e_idx = 0; e_r1 = '0; q.delete();
    end else begin
      bit win, call, push, pop, done;
      win  = in_win(m_addr);
      call = m_valid && win && !m_addr[0] && !e_busy;
      push = m_valid && win && m_addr[0] && (q.size() < DEPTH);
      pop  = pop_req && (q.size() > 0);
      done = mac_done && e_busy;
      if (done) q.delete();
      else if (pop) void'(q.pop_front());
      if (push) q.push_back(m_data);
      e_start = call;
      if (call) begin
        e_busy = 1; e_idx = (int'(m_addr) - BASE) / 2; e_r1 = m_data;
      end else if (done) e_busy = 0;
    end
  end

  task automatic chk(input string tag, input string nm, input logic [31:0] act,
                     input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at %0t: actual=%h expected=%h", tag, nm, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!fin) begin
      bit win;
      logic exp_rdy;
      string rt, bt;
      win = in_win(m_addr);
      if (!win) begin exp_rdy = fwd_ready; rt = "R1"; end
      else if (!m_addr[0]) begin exp_rdy = !e_busy; rt = "R6"; end
      else begin exp_rdy = (q.size() < DEPTH); rt = "R7"; end
      bt = rst_n ? "R8" : "R10";
      if (m_valid) chk(rt, "m_ready", 32'(m_ready), 32'(exp_rdy));
      chk("R1", "fwd_valid", 32'(fwd_valid), 32'(m_valid && !win));
      if (fwd_valid) begin
        chk("R1", "fwd_addr", 32'(fwd_addr), 32'(m_addr));
        chk("R1", "fwd_data", fwd_data, m_data);
      end
      chk(rst_n ? "R2" : "R10", "mac_start", 32'(mac_start), 32'(e_start));
      chk(rst_n ? "R2" : "R10", "mac_index", 32'(mac_index), 32'(e_idx));
      chk(rst_n ? "R2" : "R10", "mac_r1", mac_r1, e_r1);
      chk(bt, "mac_busy", 32'(mac_busy), 32'(e_busy));
      chk(rst_n ? "R5 (R3 R8 R9)" : "R10", "pop_valid", 32'(pop_valid),
          32'(q.size() > 0));
      if (q.size() > 0) chk("R4", "pop_data", pop_data, q[0]);
    end
  end

  task automatic cyc(input bit v, input int a, input logic [31:0] d,
                     input bit p, input bit dn, input bit fr);
    @(negedge clk);
    m_valid = v; m_addr = 12'(a); m_data = d;
    pop_req = p; mac_done = dn; fwd_ready = fr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!fin) begin
      fin = 1'b1;
      mismatched++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle(3);                                   // R10 reset state
    @(negedge clk); rst_n = 1'b1;
    idle(1);
    // R1 pass-through, both sides of the window
    cyc(1, 'h100, 32'h0000_00A5, 0, 0, 1);
    cyc(1, 'hDFF, 32'h1111_2222, 0, 0, 0);
    cyc(1, 'hDFF, 32'h1111_2222, 0, 0, 1);
    cyc(1, 'hF00, 32'h3333_4444, 0, 0, 1);
    // R9 pushes before any call, done while idle
    cyc(1, 'hE01, 32'd11, 0, 0, 0);
    cyc(1, 'hE01, 32'd22, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    idle(1);
    // R2 R3 call macro 3
    cyc(1, 'hE06, 32'h1234_5678, 0, 0, 0);
    idle(2);
    // R4 R5 pops, then stall on empty, push+pop on empty
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(1, 'hE07, 32'd33, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    idle(1);
    // R6 call while busy, completion with call pending
    cyc(1, 'hE0A, 32'h0000_BEEF, 0, 0, 0);
    cyc(1, 'hE0A, 32'h0000_BEEF, 0, 0, 0);
    cyc(1, 'hE0A, 32'h0000_BEEF, 0, 1, 0);
    cyc(1, 'hE0A, 32'h0000_BEEF, 0, 0, 0);
    cyc(1, 'hE0A, 32'h0000_BEEF, 0, 0, 0);
    idle(1);
    // R7 fill past depth, refused push with pop at full
    for (int i = 0; i < 5; i++) cyc(1, 'hE0B, 32'h100 + 32'(i), 0, 0, 0);
    cyc(1, 'hE0B, 32'h105, 1, 0, 0);
    cyc(1, 'hE0B, 32'h106, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    // R8 completion with simultaneous push
    cyc(1, 'hE0B, 32'h77, 0, 1, 0);
    idle(1);
    cyc(0, 0, 0, 1, 0, 0);
    idle(1);
    // Last and first macro of the window
    cyc(1, 'hEFE, 32'h0000_CAFE, 0, 0, 0);
    cyc(1, 'hEFF, 32'h0000_0042, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(1, 'hE00, 32'hDEAD_0001, 0, 0, 0);
    idle(2);
    cyc(0, 0, 0, 0, 1, 0);
    idle(3);
    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule